// File: doc/BRIEF.md
# Serial-Framed Four-Pin GPIO Configurator

This block is a 16-bit serial slave that owns four general-purpose pins. A host sends frames over an active-low select, a serial clock and a data line. Each frame can carry one of two commands. A program command sets pin directions and gives pins dedicated roles: alarm outputs, a range-select input and a power-down input. A data command carries output levels and a read-enable flag. The alarm flags come from an external threshold comparator and are routed to the pins that carry the alarm role.

Nothing a frame writes reaches the pins at once. A decoded frame fills a set of staged registers. The staged values become active on the next falling edge of the select, which is also when the input pins are sampled for readback. A soft-reset request is deferred in the same way. All serial lines pass through a parameterised synchroniser into the system clock domain.

Top module: `gpio_spi_cfg`

## Requirements
- R1: After reset every pin has output enable 0 and output level 0, range_sel and pwr_down are 0, and spi_sdo is 0.
- R2: Frames use mode 0 with the MSB first, and spi_sdi is sampled on rising spi_sclk. A frame in which the select rises after fewer than 16 rising clocks changes no register.
- R3: A frame whose bits 15:12 are 0100 and whose bits 11:10 are 00 is a program frame. A frame with code 0100 and bits 11:10 not 00 is ignored entirely.
- R4: Values written by a frame take effect at the pins only at the next falling edge of spi_csn.
- R5: For a pin with no dedicated role, program bit N (N = 0..3) gives its direction, with 1 meaning output. gpio_oe[N] follows that bit, and an output pin drives its stored level.
- R6: Program bit 8 = 1 makes pin 3 an input (oe 0), and pwr_down then follows gpio_in[3]. When the bit is 0, pwr_down is 0.
- R7: Program bit 7 = 1 makes pin 2 an input (oe 0), and range_sel then follows gpio_in[2]. When the bit is 0, range_sel is 0.
- R8: The alarm field is bits 6:4, and its roles override the direction bits. Code 000 assigns nothing. Any odd code drives pin 0 with alarm_hi OR alarm_lo. Code 010 drives pin 0 with alarm_hi. Code 100 drives pin 1 with alarm_lo. Code 110 drives pin 1 with alarm_lo and pin 0 with alarm_hi. All alarm levels are active high.
- R9: A data frame has code 0001 in bits 15:12. Its bits 3:0 are the output levels for pins 3..0, and its bit 4 is the read-enable flag.
- R10: gpio_in is sampled at the select falling edge. In that frame spi_sdo shifts out {12'b0, sample}, MSB first and changing on falling spi_sclk, but only if the latest data frame set read-enable. Otherwise spi_sdo shifts out all zeros.
- R11: Program bit 9 = 1 leaves the other fields unstaged. At the next select falling edge every register, staged and active, returns to 0, and that frame reads back zeros.
- R12: Frames with any other code in bits 15:12 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial readback data |
| gpio_in | input | PIN_N | Levels sensed on the pins |
| gpio_out | output | PIN_N | Levels driven on the pins |
| gpio_oe | output | PIN_N | Per-pin output enable |
| alarm_hi | input | 1 | High-threshold alarm flag |
| alarm_lo | input | 1 | Low-threshold alarm flag |
| range_sel | output | 1 | Range request taken from pin 2 |
| pwr_down | output | 1 | Power-down request taken from pin 3 |

## Verification
The hardest case to reach is the two-frame delay. A value written in one frame shows up only after the next select edge, so every checked effect needs a following frame, and a read-back needs a data frame that sets read-enable before the frame that carries the read. The stimulus therefore sends frames in pairs and triples. A cycle-accurate behavioural model tracks staged and active state, so each pin is compared on every clock outside the short window after a select edge. Short frames, reserved-bit program frames and unknown codes are each followed by filler frames, so that any wrongly staged value would show up at the pins. All eight alarm codes are swept with all four flag combinations.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
   localparam logic [3:0] CMD_PROG = 4'b0100;
   localparam logic [3:0] CMD_DATA = 4'b0001;

   typedef struct packed {
      logic       pd_fn;
      logic       rng_fn;
      logic [2:0] alarm_sel;
      logic [3:0] dir;
   } gcfg_cfg_t;

   localparam int CFG_W = $bits(gcfg_cfg_t);
endpackage

// File: rtl/gcfg_frame_rx.sv
module gcfg_frame_rx #(
   parameter int FRAME_W = 16,
   parameter int SYNC_N  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csn_i,
   input  logic               sclk_i,
   input  logic               sdi_i,
   output logic               csn_low_o,
   output logic               frame_start_o,
   output logic               frame_end_o,
   output logic               frame_ok_o,
   output logic               sclk_fall_o,
   output logic [FRAME_W-1:0] frame_word_o
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [SYNC_N-1:0] csn_s, sclk_s, sdi_s;
   logic              csn_prev, sclk_prev;
   logic [CNT_W-1:0]  bit_cnt;
   logic              csn_now, sclk_now, sdi_now, sclk_rise;

   for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               csn_s[0]  <= 1'b1;
               sclk_s[0] <= 1'b0;
               sdi_s[0]  <= 1'b0;
            end else begin
               csn_s[0]  <= csn_i;
               sclk_s[0] <= sclk_i;
               sdi_s[0]  <= sdi_i;
            end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               csn_s[s]  <= 1'b1;
               sclk_s[s] <= 1'b0;
               sdi_s[s]  <= 1'b0;
            end else begin
               csn_s[s]  <= csn_s[s-1];
               sclk_s[s] <= sclk_s[s-1];
               sdi_s[s]  <= sdi_s[s-1];
            end
      end
   end

   assign csn_now  = csn_s[SYNC_N-1];
   assign sclk_now = sclk_s[SYNC_N-1];
   assign sdi_now  = sdi_s[SYNC_N-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         csn_prev  <= 1'b1;
         sclk_prev <= 1'b0;
      end else begin
         csn_prev  <= csn_now;
         sclk_prev <= sclk_now;
      end

   assign frame_start_o = csn_prev & ~csn_now;
   assign frame_end_o   = ~csn_prev & csn_now;
   assign sclk_rise     = ~sclk_prev & sclk_now & ~csn_now;
   assign sclk_fall_o   = sclk_prev & ~sclk_now & ~csn_now;
   assign csn_low_o     = ~csn_now;
   assign frame_ok_o    = (bit_cnt == CNT_W'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         bit_cnt      <= '0;
         frame_word_o <= '0;
      end else if (frame_start_o) begin
         bit_cnt      <= '0;
         frame_word_o <= '0;
      end else if (sclk_rise && (bit_cnt < CNT_W'(FRAME_W))) begin
         bit_cnt      <= bit_cnt + CNT_W'(1);
         frame_word_o <= {frame_word_o[FRAME_W-2:0], sdi_now};
      end
endmodule

// File: rtl/gcfg_regs.sv
module gcfg_regs
   import gcfg_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int PIN_N   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start_i,
   input  logic               frame_end_i,
   input  logic               frame_ok_i,
   input  logic [FRAME_W-1:0] frame_word_i,
   output gcfg_cfg_t          cfg_act_o,
   output gcfg_cfg_t          cfg_stage_o,
   output logic [PIN_N-1:0]   out_act_o,
   output logic [PIN_N-1:0]   out_stage_o,
   output logic               rd_en_act_o,
   output logic               rd_load_o,
   output logic               rst_pend_o
);
   localparam int CMD_LSB  = FRAME_W - 4;
   localparam int RSV_LSB  = 10;
   localparam int RST_BIT  = 9;
   localparam int RDEN_BIT = PIN_N;

   logic [3:0] cmd;
   logic       rd_stage, prog_hit, data_hit;

   assign cmd      = frame_word_i[CMD_LSB +: 4];
   assign prog_hit = frame_end_i && frame_ok_i && (cmd == CMD_PROG) &&
                     (frame_word_i[RSV_LSB +: 2] == 2'b00);
   assign data_hit = frame_end_i && frame_ok_i && (cmd == CMD_DATA);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cfg_act_o   <= '0;
         cfg_stage_o <= '0;
         out_act_o   <= '0;
         out_stage_o <= '0;
         rd_en_act_o <= 1'b0;
         rd_stage    <= 1'b0;
         rst_pend_o  <= 1'b0;
      end else if (frame_start_i) begin
         if (rst_pend_o) begin
            cfg_act_o   <= '0;
            cfg_stage_o <= '0;
            out_act_o   <= '0;
            out_stage_o <= '0;
            rd_en_act_o <= 1'b0;
            rd_stage    <= 1'b0;
            rst_pend_o  <= 1'b0;
         end else begin
            cfg_act_o   <= cfg_stage_o;
            out_act_o   <= out_stage_o;
            rd_en_act_o <= rd_stage;
         end
      end else if (prog_hit) begin
         if (frame_word_i[RST_BIT]) rst_pend_o <= 1'b1;
         else cfg_stage_o <= gcfg_cfg_t'(frame_word_i[CFG_W-1:0]);
      end else if (data_hit) begin
         out_stage_o <= frame_word_i[PIN_N-1:0];
         rd_stage    <= frame_word_i[RDEN_BIT];
      end

   assign rd_load_o = rd_stage & ~rst_pend_o;
endmodule

// File: rtl/gcfg_pin_mux.sv
module gcfg_pin_mux
   import gcfg_pkg::*;
#(
   parameter int PIN_N = 4
) (
   input  gcfg_cfg_t        cfg_i,
   input  logic [PIN_N-1:0] out_i,
   input  logic [PIN_N-1:0] gpio_in_i,
   input  logic             alarm_hi_i,
   input  logic             alarm_lo_i,
   output logic [PIN_N-1:0] gpio_out_o,
   output logic [PIN_N-1:0] gpio_oe_o,
   output logic             range_sel_o,
   output logic             pwr_down_o
);
   localparam int HI_PIN  = 0;
   localparam int LO_PIN  = 1;
   localparam int RNG_PIN = 2;
   localparam int PD_PIN  = 3;

   logic [PIN_N-1:0] base_oe, base_out;
   logic             hi_role, lo_role;

   for (genvar p = 0; p < PIN_N; p++) begin : g_pin
      assign base_oe[p]  = cfg_i.dir[p];
      assign base_out[p] = cfg_i.dir[p] & out_i[p];
   end

   assign hi_role = cfg_i.alarm_sel[0] | cfg_i.alarm_sel[1];
   assign lo_role = ~cfg_i.alarm_sel[0] & cfg_i.alarm_sel[2];

   always_comb begin
      gpio_oe_o  = base_oe;
      gpio_out_o = base_out;
      if (cfg_i.pd_fn) begin
         gpio_oe_o[PD_PIN]  = 1'b0;
         gpio_out_o[PD_PIN] = 1'b0;
      end
      if (cfg_i.rng_fn) begin
         gpio_oe_o[RNG_PIN]  = 1'b0;
         gpio_out_o[RNG_PIN] = 1'b0;
      end
      if (hi_role) begin
         gpio_oe_o[HI_PIN]  = 1'b1;
         gpio_out_o[HI_PIN] = cfg_i.alarm_sel[0] ? (alarm_hi_i | alarm_lo_i) : alarm_hi_i;
      end
      if (lo_role) begin
         gpio_oe_o[LO_PIN]  = 1'b1;
         gpio_out_o[LO_PIN] = alarm_lo_i;
      end
   end

   assign pwr_down_o  = cfg_i.pd_fn  & gpio_in_i[PD_PIN];
   assign range_sel_o = cfg_i.rng_fn & gpio_in_i[RNG_PIN];
endmodule

// File: rtl/gcfg_tx_shift.sv
module gcfg_tx_shift #(
   parameter int FRAME_W = 16,
   parameter int PIN_N   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic             load_en_i,
   input  logic             sclk_fall_i,
   input  logic             csn_low_i,
   input  logic [PIN_N-1:0] gpio_in_i,
   output logic             sdo_o
);
   logic [FRAME_W-1:0] tx;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             tx <= '0;
      else if (frame_start_i) tx <= load_en_i ? FRAME_W'(gpio_in_i) : '0;
      else if (sclk_fall_i)   tx <= {tx[FRAME_W-2:0], 1'b0};

   assign sdo_o = csn_low_i & tx[FRAME_W-1];
endmodule

// File: rtl/gpio_spi_cfg.sv
module gpio_spi_cfg
   import gcfg_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int PIN_N   = 4,
   parameter int SYNC_N  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_csn,
   input  logic             spi_sclk,
   input  logic             spi_sdi,
   output logic             spi_sdo,
   input  logic [PIN_N-1:0] gpio_in,
   output logic [PIN_N-1:0] gpio_out,
   output logic [PIN_N-1:0] gpio_oe,
   input  logic             alarm_hi,
   input  logic             alarm_lo,
   output logic             range_sel,
   output logic             pwr_down
);
   if (FRAME_W != 16) begin : g_bad_frame
      $error("gpio_spi_cfg: FRAME_W must be 16");
   end
   if (PIN_N != 4) begin : g_bad_pins
      $error("gpio_spi_cfg: PIN_N must be 4");
   end
   if (SYNC_N < 1) begin : g_bad_sync
      $error("gpio_spi_cfg: SYNC_N must be at least 1");
   end

   logic               csn_low, frame_start, frame_end, frame_ok, sclk_fall;
   logic [FRAME_W-1:0] frame_word;
   gcfg_cfg_t          cfg_act, cfg_stage;
   logic [PIN_N-1:0]   out_act, out_stage;
   logic               rd_en_act, rd_load, rst_pend;

   gcfg_frame_rx #(.FRAME_W(FRAME_W), .SYNC_N(SYNC_N)) u_rx (
      .clk(clk), .rst_n(rst_n), .csn_i(spi_csn), .sclk_i(spi_sclk), .sdi_i(spi_sdi),
      .csn_low_o(csn_low), .frame_start_o(frame_start), .frame_end_o(frame_end),
      .frame_ok_o(frame_ok), .sclk_fall_o(sclk_fall), .frame_word_o(frame_word));

   gcfg_regs #(.FRAME_W(FRAME_W), .PIN_N(PIN_N)) u_regs (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .frame_end_i(frame_end),
      .frame_ok_i(frame_ok), .frame_word_i(frame_word), .cfg_act_o(cfg_act),
      .cfg_stage_o(cfg_stage), .out_act_o(out_act), .out_stage_o(out_stage),
      .rd_en_act_o(rd_en_act), .rd_load_o(rd_load), .rst_pend_o(rst_pend));

   gcfg_pin_mux #(.PIN_N(PIN_N)) u_mux (
      .cfg_i(cfg_act), .out_i(out_act), .gpio_in_i(gpio_in), .alarm_hi_i(alarm_hi),
      .alarm_lo_i(alarm_lo), .gpio_out_o(gpio_out), .gpio_oe_o(gpio_oe),
      .range_sel_o(range_sel), .pwr_down_o(pwr_down));

   gcfg_tx_shift #(.FRAME_W(FRAME_W), .PIN_N(PIN_N)) u_tx (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .load_en_i(rd_load),
      .sclk_fall_i(sclk_fall), .csn_low_i(csn_low), .gpio_in_i(gpio_in), .sdo_o(spi_sdo));
endmodule

// File: rtl/gcfg_chk.sv
module gcfg_chk #(
   parameter int PIN_N = 4,
   parameter int CW    = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             frame_end,
   input logic             frame_ok,
   input logic [CW-1:0]    cfg_act,
   input logic [CW-1:0]    cfg_stage,
   input logic [PIN_N-1:0] out_act,
   input logic [PIN_N-1:0] out_stage,
   input logic             rd_en_act,
   input logic             rst_pend,
   input logic [PIN_N-1:0] gpio_oe,
   input logic             spi_sdo,
   input logic             range_sel,
   input logic             pwr_down
);
   logic started;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;

   // R6
   pd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !gpio_oe[3]);

   // R7
   rng_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      range_sel |-> !gpio_oe[2]);

   // R4
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(frame_start)) |-> $stable(gpio_oe));

   // R2
   short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !frame_ok) |=> ($stable(cfg_stage) && $stable(out_stage) && $stable(rst_pend)));

   // R11
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && rst_pend) |=> (!rst_pend && cfg_act == '0 && out_act == '0 && !rd_en_act));

   // R10
   sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_act |-> !spi_sdo);
endmodule

bind gpio_spi_cfg gcfg_chk #(.PIN_N(PIN_N), .CW(gcfg_pkg::CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
   .frame_ok(frame_ok), .cfg_act(cfg_act), .cfg_stage(cfg_stage), .out_act(out_act),
   .out_stage(out_stage), .rd_en_act(rd_en_act), .rst_pend(rst_pend), .gpio_oe(gpio_oe),
   .spi_sdo(spi_sdo), .range_sel(range_sel), .pwr_down(pwr_down));

// File: tb/gpio_spi_cfg_bench.sv
module gpio_spi_cfg_bench;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
   logic spi_sdo;
   logic [3:0] gpio_in = 4'h0;
   logic [3:0] gpio_out, gpio_oe;
   logic alarm_hi = 1'b0, alarm_lo = 1'b0;
   logic range_sel, pwr_down;

   always #4 clk = ~clk;

   gpio_spi_cfg u_gpio_spi_cfg (
      .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
      .spi_sdo(spi_sdo), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .alarm_hi(alarm_hi), .alarm_lo(alarm_lo), .range_sel(range_sel), .pwr_down(pwr_down));

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit cmp_en = 1'b0;

   bit [8:0]  m_cfg_stage, m_cfg_act;
   bit [3:0]  m_out_stage, m_out_act;
   bit        m_rd_stage, m_rd_act, m_rst_pend;
   bit [15:0] exp_rb;

   task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit [9:0] model_pins();
      bit [3:0] oe, out;
      bit rng, pd;
      oe  = m_cfg_act[3:0];
      out = m_cfg_act[3:0] & m_out_act;
      if (m_cfg_act[8]) begin oe[3] = 0; out[3] = 0; end
      if (m_cfg_act[7]) begin oe[2] = 0; out[2] = 0; end
      case (m_cfg_act[6:4])
         3'd1, 3'd3, 3'd5, 3'd7: begin oe[0] = 1; out[0] = alarm_hi | alarm_lo; end
         3'd2: begin oe[0] = 1; out[0] = alarm_hi; end
         3'd4: begin oe[1] = 1; out[1] = alarm_lo; end
         3'd6: begin oe[1] = 1; out[1] = alarm_lo; oe[0] = 1; out[0] = alarm_hi; end
         default: ;
      endcase
      pd  = m_cfg_act[8] && gpio_in[3];
      rng = m_cfg_act[7] && gpio_in[2];
      return {oe, out, rng, pd};
   endfunction

   task automatic expect_pins(string req);
      chk(req, "oe/out/range/pd", 16'({gpio_oe, gpio_out, range_sel, pwr_down}), 16'(model_pins()));
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && cmp_en) expect_pins(cur_req);
   end

   task automatic model_start();
      if (m_rst_pend) begin
         m_cfg_stage = 0; m_cfg_act = 0; m_out_stage = 0; m_out_act = 0;
         m_rd_stage = 0; m_rd_act = 0; m_rst_pend = 0; exp_rb = 0;
      end else begin
         exp_rb    = m_rd_stage ? {12'h000, gpio_in} : 16'h0000;
         m_cfg_act = m_cfg_stage;
         m_out_act = m_out_stage;
         m_rd_act  = m_rd_stage;
      end
   endtask

   task automatic model_end(bit [15:0] w);
      if (w[15:12] == 4'b0100 && w[11:10] == 2'b00) begin
         if (w[9]) m_rst_pend = 1;
         else m_cfg_stage = w[8:0];
      end else if (w[15:12] == 4'b0001) begin
         m_out_stage = w[3:0];
         m_rd_stage  = w[4];
      end
   endtask

   task automatic send_bits(bit [15:0] w, int nbits);
      @(negedge clk);
      cmp_en  = 0;
      spi_csn = 0;
      repeat (H) @(negedge clk);
      model_start();
      cmp_en = 1;
      for (int i = 0; i < nbits; i++) begin
         spi_sdi = w[15-i];
         repeat (H) @(negedge clk);
         chk((cur_req == "R11") ? "R11" : "R10", "sdo bit", 16'(spi_sdo), 16'(exp_rb[15-i]));
         spi_sclk = 1;
         repeat (H) @(negedge clk);
         spi_sclk = 0;
      end
      repeat (H) @(negedge clk);
      spi_csn = 1;
      repeat (H) @(negedge clk);
      if (nbits == 16) model_end(w);
   endtask

   task automatic send(bit [15:0] w);
      send_bits(w, 16);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "oe", 16'(gpio_oe), 16'h0);
      chk("R1", "out", 16'(gpio_out), 16'h0);
      chk("R1", "sdo", 16'(spi_sdo), 16'h0);
      chk("R1", "range/pd", 16'({range_sel, pwr_down}), 16'h0);
      cmp_en = 1;

      // R5 directions, R4 deferral
      cur_req = "R5";
      send(16'h400F);
      chk("R4", "oe before next frame", 16'(gpio_oe), 16'h0);
      send(16'h100A);
      chk("R4", "oe after next frame", 16'(gpio_oe), 16'hF);
      chk("R4", "out not yet applied", 16'(gpio_out), 16'h0);
      send(16'h0000);
      chk("R5", "out levels", 16'(gpio_out), 16'hA);

      // R9 data frame
      cur_req = "R9";
      send(16'h1005);
      send(16'h0000);
      chk("R9", "out levels", 16'(gpio_out), 16'h5);
      send(16'h4003);
      send(16'h0000);
      chk("R9", "out masked by direction", 16'(gpio_out), 16'h1);
      send(16'h400F);

      // R10 readback
      cur_req = "R10";
      gpio_in = 4'b0110;
      send(16'h1015);
      send(16'h1015);
      gpio_in = 4'b1001;
      send(16'h1005);
      send(16'h0000);
      gpio_in = 4'b1111;
      send(16'h0000);

      // R6 / R7 dedicated inputs
      cur_req = "R6";
      send(16'h418F);
      send(16'h0000);
      for (int g = 0; g < 16; g += 4) begin
         @(negedge clk);
         gpio_in = 4'(g);
         repeat (2) @(negedge clk);
         expect_pins("R6");
         expect_pins("R7");
      end
      cur_req = "R7";
      send(16'h408F);
      send(16'h0000);
      gpio_in = 4'b1100;
      repeat (2) @(negedge clk);
      chk("R7", "range follows pin2", 16'(range_sel), 16'h1);
      chk("R6", "pd off", 16'(pwr_down), 16'h0);

      // R8 alarm codes
      cur_req = "R8";
      for (int a = 0; a < 8; a++) begin
         send(16'h4000 | 16'(a << 4) | 16'h0000);
         send(16'h0000);
         for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            alarm_hi = f[0];
            alarm_lo = f[1];
            repeat (2) @(negedge clk);
            expect_pins("R8");
         end
      end
      alarm_hi = 1; alarm_lo = 0;

      // R3 reserved bits
      cur_req = "R3";
      send(16'h4000 | 16'h0050 | 16'h000C);
      send(16'h0000);
      send(16'h4400);
      send(16'h4800);
      send(16'h4E00);
      send(16'h0000);
      chk("R3", "oe unchanged", 16'(gpio_oe), 16'hD);

      // R2 short frames
      cur_req = "R2";
      send_bits(16'h4000, 8);
      send_bits(16'h100F, 15);
      send(16'h0000);
      send(16'h0000);
      chk("R2", "oe unchanged", 16'(gpio_oe), 16'hD);

      // R12 unknown codes
      cur_req = "R12";
      send(16'h2000);
      send(16'hF000);
      send(16'h8000);
      send(16'h0000);
      chk("R12", "oe unchanged", 16'(gpio_oe), 16'hD);

      // R11 soft reset
      cur_req = "R11";
      gpio_in = 4'b0101;
      send(16'h101F);
      send(16'h42FF);
      send(16'h0000);
      chk("R11", "oe cleared", 16'(gpio_oe), 16'h0);
      chk("R11", "out cleared", 16'(gpio_out), 16'h0);
      send(16'h0000);

      cmp_en = 0;
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end
endmodule